// File: doc/BRIEF.md
# Multiplexed-Bus External SRAM Bridge

This block joins a processor with a time-shared address/data byte lane to one asynchronous byte-wide SRAM. A dedicated high port carries the upper address byte. The shared low lane first carries the lower address byte and then the data or instruction byte. A holding register keeps the lower address once the address strobe drops, and it is transparent while the strobe is high. The active-low fetch strobe becomes the most significant SRAM address bit. This places instructions in the lower half of the part and data in the upper half, so one part can hold both program and data.

Small glue logic forms the active-low chip enable and output enable from the read, write and fetch strobes. The write strobe goes straight to the SRAM write enable. The bidirectional lane is modelled as a separate input byte, an output byte and a drive flag. The SRAM array sits inside the block and is sampled on the clock. With `HI_W = 8` the block is the full 128K x 8 arrangement. The default is smaller so that elaboration stays cheap.

Top module: `xbus_sram_bridge`

## Requirements
- R1: After reset the held low address is 0, and with all strobes high `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1 and `ad_drive` is 0.
- R2: While `addr_stb` is 1, the low address follows `ad_in`. At each clock edge with `addr_stb` at 1, `ad_in` is captured and then held for as long as `addr_stb` stays 0.
- R3: The SRAM address is {`fetch_n`, `hi_addr`, low address}, with `fetch_n` as the top bit. A fetch (`fetch_n` = 0) and a data read (`rd_n` = 0) at the same 16-bit address reach different locations.
- R4: `mem_oe_n` is 0 exactly when `rd_n` or `fetch_n` is 0.
- R5: `mem_ce_n` is 0 exactly when any of `rd_n`, `wr_n` or `fetch_n` is 0.
- R6: `mem_we_n` equals `wr_n` at all times.
- R7: At a clock edge with `mem_ce_n` = 0 and `mem_we_n` = 0, the byte on `ad_in` is stored at the current SRAM address. A write made with `fetch_n` = 0 lands in the lower half.
- R8: `ad_drive` is 1 exactly when `mem_ce_n` = 0, `mem_oe_n` = 0, `mem_we_n` = 1 and `cpu_drive` = 0. While driving, `ad_out` is the stored byte at the current address. Otherwise `ad_out` is 0.
- R9: `ad_drive` and `cpu_drive` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the address holding register and the array write |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_addr | input | HI_W | Upper address byte from the high port |
| ad_in | input | 8 | Shared lane as driven by the processor |
| cpu_drive | input | 1 | Processor is driving the shared lane |
| addr_stb | input | 1 | Low address present on the shared lane |
| fetch_n | input | 1 | Active-low instruction fetch strobe |
| rd_n | input | 1 | Active-low data read strobe |
| wr_n | input | 1 | Active-low data write strobe |
| ad_out | output | 8 | Shared lane as driven by the SRAM |
| ad_drive | output | 1 | SRAM is driving the shared lane |
| mem_ce_n | output | 1 | SRAM chip enable, active low |
| mem_oe_n | output | 1 | SRAM output enable, active low |
| mem_we_n | output | 1 | SRAM write enable, active low |

## Verification
The bench builds the block with `HI_W = 3`, which gives a 4096-byte array. Several high-port values then reach distinct rows in both halves of memory, while the array stays small. Both halves are filled at identical 11-bit addresses with different bytes. Lane contention and the holding register's behaviour after the lane changes to data are checked at the same time.

// File: rtl/xbus_sram_bridge.sv
module xbus_sram_bridge #(
  parameter int HI_W = 2,
  localparam int LO_W = 8,
  localparam int AW = 1 + HI_W + LO_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HI_W-1:0] hi_addr,
  input  logic [LO_W-1:0] ad_in,
  input  logic            cpu_drive,
  input  logic            addr_stb,
  input  logic            fetch_n,
  input  logic            rd_n,
  input  logic            wr_n,
  output logic [LO_W-1:0] ad_out,
  output logic            ad_drive,
  output logic            mem_ce_n,
  output logic            mem_oe_n,
  output logic            mem_we_n
);

  logic [LO_W-1:0] lo_q;
  logic [LO_W-1:0] lo_addr;
  logic [AW-1:0]   addr;
  logic [LO_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n)        lo_q <= '0;
    else if (addr_stb) lo_q <= ad_in;
  end

  assign lo_addr  = addr_stb ? ad_in : lo_q;
  assign addr     = {fetch_n, hi_addr, lo_addr};

  assign mem_oe_n = rd_n & fetch_n;
  assign mem_ce_n = rd_n & wr_n & fetch_n;
  assign mem_we_n = wr_n;

  always_ff @(posedge clk) begin
    if (!mem_ce_n && !mem_we_n) mem[addr] <= ad_in;
  end

  assign ad_drive = !mem_ce_n && !mem_oe_n && mem_we_n && !cpu_drive;
  assign ad_out   = ad_drive ? mem[addr] : '0;

  // R9
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ad_drive && cpu_drive));

  // R4
  oe_within_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n);

  // R4
  fetch_opens_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_n |-> !mem_oe_n);

  // R2
  addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb |=> (lo_q == $past(ad_in)));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_stb |=> $stable(lo_q));

  // R8
  quiet_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_drive |-> (ad_out == '0));

endmodule

// File: tb/xbus_sram_bridge_tb.sv
`timescale 1ns/1ps
module xbus_sram_bridge_tb;
  localparam int HI_W = 3;
  localparam int AW = 1 + HI_W + 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic [HI_W-1:0] hi_addr = '0;
  logic [7:0] ad_in = '0;
  logic cpu_drive = 0, addr_stb = 0, fetch_n = 1, rd_n = 1, wr_n = 1;
  logic [7:0] ad_out;
  logic ad_drive, mem_ce_n, mem_oe_n, mem_we_n;

  int vectors = 0, miscompares = 0;
  int ref_mem [DEPTH];
  int ref_lo = 0;

  always #4 clk = ~clk;

  xbus_sram_bridge #(.HI_W(HI_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .hi_addr(hi_addr), .ad_in(ad_in),
    .cpu_drive(cpu_drive), .addr_stb(addr_stb), .fetch_n(fetch_n),
    .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_drive(ad_drive),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n));

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int cur_addr();
    int lo = addr_stb ? int'(ad_in) : ref_lo;
    return (int'(fetch_n) << (AW - 1)) | (int'(hi_addr) << 8) | lo;
  endfunction

  // drive at negedge, compare mid-low phase, update model at posedge
  task automatic step(bit stb, bit cd, bit f, bit r, bit w, logic [7:0] d);
    int a, e_ce, e_oe, e_drv, e_out;
    @(negedge clk);
    addr_stb = stb; cpu_drive = cd; fetch_n = f; rd_n = r; wr_n = w; ad_in = d;
    #1;
    a = cur_addr();
    e_oe = r & f;                       // R4
    e_ce = r & w & f;                   // R5
    e_drv = (!e_ce && !e_oe && w && !cd) ? 1 : 0;
    check("R4", int'(mem_oe_n), e_oe);
    check("R5", int'(mem_ce_n), e_ce);
    check("R6", int'(mem_we_n), int'(w));
    check("R8", int'(ad_drive), e_drv);
    check("R9", int'(ad_drive && cpu_drive), 0);
    if (e_drv && ref_mem[a] >= 0) begin
      e_out = ref_mem[a];
      check("R3/R8", int'(ad_out), e_out);
    end else if (!e_drv) check("R8", int'(ad_out), 0);
    @(posedge clk);
    if (!e_ce && !w) ref_mem[a] = int'(d);   // R7
    if (stb) ref_lo = int'(d);               // R2
  endtask

  task automatic wr_cycle(bit to_code, logic [HI_W-1:0] h, logic [7:0] lo, logic [7:0] d);
    @(negedge clk); hi_addr = h;
    step(1, 1, 1, 1, 1, lo);
    step(0, 1, !to_code, 1, 0, d);          // R7 write
    step(0, 0, 1, 1, 1, 8'h00);
  endtask

  task automatic rd_cycle(bit fetch, logic [HI_W-1:0] h, logic [7:0] lo);
    @(negedge clk); hi_addr = h;
    step(1, 1, 1, 1, 1, lo);
    step(0, 0, !fetch, fetch, 1, ~lo);      // R2: lane no longer holds address
    step(0, 0, 1, 1, 1, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = -1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    #1;
    check("R1", int'(mem_ce_n), 1);
    check("R1", int'(mem_oe_n), 1);
    check("R1", int'(mem_we_n), 1);
    check("R1", int'(ad_drive), 0);
    // R1: held low address is 0 -> write at lo 0 without strobing
    step(0, 1, 1, 1, 0, 8'h5A);
    step(0, 0, 1, 1, 1, 8'h00);
    rd_cycle(0, 0, 8'h00);
    // R7: preload code half and data half at identical 11-bit addresses
    for (int k = 0; k < 8; k++) begin
      wr_cycle(1, HI_W'(k), 8'(8'h10 + k * 17), 8'(8'hC0 + k));
      wr_cycle(0, HI_W'(k), 8'(8'h10 + k * 17), 8'(8'h30 + k));
    end
    // R3: fetch and data read of the same address differ
    for (int k = 0; k < 8; k++) begin
      rd_cycle(1, HI_W'(k), 8'(8'h10 + k * 17));
      rd_cycle(0, HI_W'(k), 8'(8'h10 + k * 17));
    end
    // R9: processor keeps driving during a read -> SRAM must stay off
    @(negedge clk); hi_addr = 3'd2;
    step(1, 1, 1, 1, 1, 8'h32);
    step(0, 1, 1, 0, 1, 8'hEE);
    step(0, 1, 0, 1, 1, 8'hEE);
    step(0, 0, 1, 1, 1, 8'h00);
    // R2: transparent read with strobe high
    @(negedge clk); hi_addr = 3'd5;
    step(1, 0, 1, 0, 1, 8'h65);
    step(0, 0, 1, 0, 1, 8'h00);
    step(0, 0, 1, 1, 1, 8'h00);
    // R5/R4 mixed strobes
    step(0, 0, 0, 0, 1, 8'h00);
    step(0, 0, 1, 1, 1, 8'h00);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule